// File: doc/BRIEF.md
# Interleaved Lane Deserializer with Per-Core Trim

This block sits behind four converter cores that sample one analog input in rotation. Every fast clock cycle it receives one 12-bit sample from each core. Core 0 holds time slot 0 of each group of four, core 1 slot 1, core 2 slot 2 and core 3 slot 3. Over four consecutive fast cycles it collects sixteen samples. It emits them as one sixteen-lane word whose lane k holds the sample taken at time slot k of that group of sixteen. The word comes with a one-cycle valid strobe that stands in for the quarter-rate clock.

Before deserializing, each core's sample is corrected by that core's own trim pair. The offset is subtracted first, then the result is multiplied by an unsigned fixed-point gain, rounded and clamped to the signed 12-bit range. Only four trim pairs exist, one per core. Output lane k is therefore always corrected with the pair of core k mod 4. A small write port loads the pairs.

A four-state slot sequencer walks SLOT_Q0, SLOT_Q1, SLOT_Q2, SLOT_Q3 and back to SLOT_Q0, one step per fast cycle. Reset forces SLOT_Q0. The step from SLOT_Q3 to SLOT_Q0 is the group wrap. Every other step advances to the next quarter of the group.

Top module: `ilv_deser`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `out_valid` low and all of `out_lanes` zero. Every core's trim returns to offset 0 and gain 0x4000, so samples pass unchanged.
- R2: Number the first rising edge with `rst` low as edge 0. `out_valid` is high for exactly one cycle after edge 5, then after every fourth edge while the stream runs, and low otherwise.
- R3: The sample on input lane c (bits 12c+11:12c of `in_lanes`) at edge 4g+p belongs to group g. After correction it appears on output lane 4p+c (bits 12(4p+c)+11:12(4p+c) of `out_lanes`).
- R4: The corrected value is (sample − offset) × gain / 16384. The offset is a signed 12-bit value and the gain is an unsigned 16-bit value with 14 fractional bits.
- R5: The division by 16384 rounds to nearest, and exact halves round toward positive infinity (1.5 → 2, −1.5 → −1).
- R6: Results above 2047 output 2047 and results below −2048 output −2048.
- R7: Output lanes k, k+4, k+8 and k+12 all use the trim pair of core k.
- R8: A write at a clock edge with `cfg_we` high and `rst` low updates core `cfg_core`. With `cfg_is_gain` = 0 it loads the offset from `cfg_wdata[11:0]` (two's complement). With `cfg_is_gain` = 1 it loads the gain from `cfg_wdata[15:0]`. Writes while `rst` is high are ignored.
- R9: All sixteen lanes change together, on the edge that raises `out_valid`. Between strobes `out_lanes` holds its value.
- R10: A reset that arrives in the middle of a group discards the partial group. The first sample after release is mapped to slot 0 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sample clock |
| rst | input | 1 | Synchronous reset, active high |
| in_lanes | input | 48 | One 12-bit signed sample per core, core c at bits 12c+11:12c |
| cfg_we | input | 1 | Trim write enable |
| cfg_core | input | 2 | Core whose trim is written |
| cfg_is_gain | input | 1 | 1 selects the gain, 0 selects the offset |
| cfg_wdata | input | 16 | Trim write value |
| out_valid | output | 1 | One-cycle strobe marking a fresh sixteen-lane word |
| out_lanes | output | 192 | Sixteen 12-bit signed corrected samples in time order, lane k at bits 12k+11:12k |

## Verification
The assertions take for granted that the cores deliver a sample on every fast cycle without gaps once reset is released. The strobe cadence and the hold between strobes are only defined for such an unbroken stream. The stimulus keeps to this: each scenario drives a fresh input word on every cycle from the release of reset until its last group has emerged. Trim writes happen in the first two groups, and those groups are not compared against a model.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

    localparam int SAMPLE_W  = 12;
    localparam int CORE_N    = 4;
    localparam int SPLIT_N   = 4;
    localparam int GAIN_W    = 16;
    localparam int GAIN_FRAC = 14;

    localparam int SLOT_W    = $clog2(SPLIT_N);
    localparam int CORE_SELW = $clog2(CORE_N);

    // Quarter of the sixteen-sample group being captured this cycle.
    typedef enum logic [SLOT_W-1:0] {
        SLOT_Q0 = 2'd0,
        SLOT_Q1 = 2'd1,
        SLOT_Q2 = 2'd2,
        SLOT_Q3 = 2'd3
    } slot_e;

    localparam logic [GAIN_W-1:0] GAIN_UNITY = GAIN_W'(1 << GAIN_FRAC);

endpackage

// File: rtl/ilv_slot_fsm.sv
module ilv_slot_fsm
    import ilv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    output logic [SLOT_W-1:0] slot_idx
);

    slot_e state_q;
    slot_e state_d;

    // Next-state: advance one quarter per cycle, wrap after the last quarter.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_Q0: state_d = SLOT_Q1;
            SLOT_Q1: state_d = SLOT_Q2;
            SLOT_Q2: state_d = SLOT_Q3;
            SLOT_Q3: state_d = SLOT_Q0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SLOT_Q0;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decode: the slot index the captured samples belong to.
    always_comb begin
        slot_idx = '0;
        unique case (state_q)
            SLOT_Q0: slot_idx = SLOT_W'(0);
            SLOT_Q1: slot_idx = SLOT_W'(1);
            SLOT_Q2: slot_idx = SLOT_W'(2);
            SLOT_Q3: slot_idx = SLOT_W'(3);
        endcase
    end

endmodule

// File: rtl/ilv_trim_bank.sv
module ilv_trim_bank #(
    parameter int CORE_N    = ilv_pkg::CORE_N,
    parameter int SAMPLE_W  = ilv_pkg::SAMPLE_W,
    parameter int GAIN_W    = ilv_pkg::GAIN_W,
    parameter int GAIN_FRAC = ilv_pkg::GAIN_FRAC,
    localparam int SEL_W    = $clog2(CORE_N)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cfg_we,
    input  logic [SEL_W-1:0]           cfg_core,
    input  logic                       cfg_is_gain,
    input  logic [GAIN_W-1:0]          cfg_wdata,
    output logic [CORE_N*SAMPLE_W-1:0] offsets,
    output logic [CORE_N*GAIN_W-1:0]   gains
);

    localparam logic [GAIN_W-1:0] UNITY = GAIN_W'(1 << GAIN_FRAC);

    for (genvar c = 0; c < CORE_N; c++) begin : g_core
        logic                hit;
        logic [SAMPLE_W-1:0] off_q;
        logic [GAIN_W-1:0]   gain_q;

        assign hit = cfg_we && (cfg_core == SEL_W'(c));

        always_ff @(posedge clk) begin
            if (rst) begin
                off_q  <= '0;
                gain_q <= UNITY;
            end else if (hit) begin
                if (cfg_is_gain) begin
                    gain_q <= cfg_wdata;
                end else begin
                    off_q <= cfg_wdata[SAMPLE_W-1:0];
                end
            end
        end

        assign offsets[c*SAMPLE_W +: SAMPLE_W] = off_q;
        assign gains[c*GAIN_W +: GAIN_W]       = gain_q;
    end

endmodule

// File: rtl/ilv_trim_path.sv
module ilv_trim_path #(
    parameter int SAMPLE_W  = ilv_pkg::SAMPLE_W,
    parameter int GAIN_W    = ilv_pkg::GAIN_W,
    parameter int GAIN_FRAC = ilv_pkg::GAIN_FRAC
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SAMPLE_W-1:0] sample_in,
    input  logic [SAMPLE_W-1:0] offset,
    input  logic [GAIN_W-1:0]   gain,
    output logic [SAMPLE_W-1:0] corr_out
);

    localparam int DIFF_W = SAMPLE_W + 1;
    localparam int GS_W   = GAIN_W + 1;
    localparam int PROD_W = DIFF_W + GS_W;
    localparam int BIAS_W = PROD_W + 1;
    localparam int SCL_W  = BIAS_W - GAIN_FRAC;

    localparam logic signed [BIAS_W-1:0] RND    = BIAS_W'(1) <<< (GAIN_FRAC - 1);
    localparam logic signed [SCL_W-1:0]  SAT_HI = SCL_W'((1 << (SAMPLE_W - 1)) - 1);
    localparam logic signed [SCL_W-1:0]  SAT_LO = -SCL_W'(1 << (SAMPLE_W - 1));

    logic        [SAMPLE_W-1:0] samp_q;
    logic signed [DIFF_W-1:0]   diff;
    logic signed [GS_W-1:0]     gain_s;
    logic signed [PROD_W-1:0]   prod;
    logic signed [BIAS_W-1:0]   biased;
    logic signed [SCL_W-1:0]    scaled;
    logic        [SAMPLE_W-1:0] clamped;

    // Stage A: capture the raw sample.
    always_ff @(posedge clk) begin
        if (rst) begin
            samp_q <= '0;
        end else begin
            samp_q <= sample_in;
        end
    end

    // Offset first, then gain, then round half up and clamp.
    always_comb begin
        diff    = $signed({samp_q[SAMPLE_W-1], samp_q}) - $signed({offset[SAMPLE_W-1], offset});
        gain_s  = $signed({1'b0, gain});
        prod    = PROD_W'(diff) * PROD_W'(gain_s);
        biased  = BIAS_W'(prod) + RND;
        scaled  = $signed(biased[BIAS_W-1:GAIN_FRAC]);
        if (scaled > SAT_HI) begin
            clamped = SAT_HI[SAMPLE_W-1:0];
        end else if (scaled < SAT_LO) begin
            clamped = SAT_LO[SAMPLE_W-1:0];
        end else begin
            clamped = scaled[SAMPLE_W-1:0];
        end
    end

    // Stage B: registered corrected sample.
    always_ff @(posedge clk) begin
        if (rst) begin
            corr_out <= '0;
        end else begin
            corr_out <= clamped;
        end
    end

endmodule

// File: rtl/ilv_gather.sv
module ilv_gather #(
    parameter int CORE_N   = ilv_pkg::CORE_N,
    parameter int SPLIT_N  = ilv_pkg::SPLIT_N,
    parameter int SAMPLE_W = ilv_pkg::SAMPLE_W,
    localparam int SLOT_W  = $clog2(SPLIT_N),
    localparam int WORD_W  = CORE_N * SAMPLE_W,
    localparam int OUT_W   = SPLIT_N * WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stage_vld,
    input  logic [SLOT_W-1:0] stage_slot,
    input  logic [WORD_W-1:0] stage_word,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_lanes
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SPLIT_N - 1);

    logic [OUT_W-1:0] assembled;
    logic             wrap;

    assign wrap = stage_vld && (stage_slot == LAST_SLOT);

    // Holding words for every slot but the last; the last bypasses them.
    for (genvar s = 0; s < SPLIT_N - 1; s++) begin : g_hold
        logic [WORD_W-1:0] hold_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                hold_q <= '0;
            end else if (stage_vld && stage_slot == SLOT_W'(s)) begin
                hold_q <= stage_word;
            end
        end

        assign assembled[s*WORD_W +: WORD_W] = hold_q;
    end

    assign assembled[(SPLIT_N-1)*WORD_W +: WORD_W] = stage_word;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_lanes <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= wrap;
            if (wrap) begin
                out_lanes <= assembled;
            end
        end
    end

endmodule

// File: rtl/ilv_deser.sv
module ilv_deser
    import ilv_pkg::*;
(
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic [CORE_N*SAMPLE_W-1:0]           in_lanes,
    input  logic                                 cfg_we,
    input  logic [CORE_SELW-1:0]                 cfg_core,
    input  logic                                 cfg_is_gain,
    input  logic [GAIN_W-1:0]                    cfg_wdata,
    output logic                                 out_valid,
    output logic [SPLIT_N*CORE_N*SAMPLE_W-1:0]   out_lanes
);

    localparam int WORD_W = CORE_N * SAMPLE_W;

    logic [SLOT_W-1:0]        slot_now;
    logic [CORE_N*SAMPLE_W-1:0] offsets;
    logic [CORE_N*GAIN_W-1:0] gains;
    logic [WORD_W-1:0]        corr_word;

    // Slot tags travel alongside the two trim stages.
    logic              a_vld, b_vld;
    logic [SLOT_W-1:0] a_slot, b_slot;

    ilv_slot_fsm i_slot (
        .clk      (clk),
        .rst      (rst),
        .slot_idx (slot_now)
    );

    ilv_trim_bank #(
        .CORE_N    (CORE_N),
        .SAMPLE_W  (SAMPLE_W),
        .GAIN_W    (GAIN_W),
        .GAIN_FRAC (GAIN_FRAC)
    ) i_bank (
        .clk         (clk),
        .rst         (rst),
        .cfg_we      (cfg_we),
        .cfg_core    (cfg_core),
        .cfg_is_gain (cfg_is_gain),
        .cfg_wdata   (cfg_wdata),
        .offsets     (offsets),
        .gains       (gains)
    );

    for (genvar c = 0; c < CORE_N; c++) begin : g_path
        ilv_trim_path #(
            .SAMPLE_W  (SAMPLE_W),
            .GAIN_W    (GAIN_W),
            .GAIN_FRAC (GAIN_FRAC)
        ) i_path (
            .clk       (clk),
            .rst       (rst),
            .sample_in (in_lanes[c*SAMPLE_W +: SAMPLE_W]),
            .offset    (offsets[c*SAMPLE_W +: SAMPLE_W]),
            .gain      (gains[c*GAIN_W +: GAIN_W]),
            .corr_out  (corr_word[c*SAMPLE_W +: SAMPLE_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_vld  <= 1'b0;
            b_vld  <= 1'b0;
            a_slot <= '0;
            b_slot <= '0;
        end else begin
            a_vld  <= 1'b1;
            a_slot <= slot_now;
            b_vld  <= a_vld;
            b_slot <= a_slot;
        end
    end

    ilv_gather #(
        .CORE_N   (CORE_N),
        .SPLIT_N  (SPLIT_N),
        .SAMPLE_W (SAMPLE_W)
    ) i_gather (
        .clk        (clk),
        .rst        (rst),
        .stage_vld  (b_vld),
        .stage_slot (b_slot),
        .stage_word (corr_word),
        .out_valid  (out_valid),
        .out_lanes  (out_lanes)
    );

endmodule

// File: rtl/ilv_deser_chk.sv
module ilv_deser_chk #(
    parameter int OUT_W = 192
) (
    input logic             clk,
    input logic             rst,
    input logic             out_valid,
    input logic [OUT_W-1:0] out_lanes
);

    logic [2:0] warm_q;
    logic [1:0] ph_q;
    logic       armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            warm_q <= '0;
            ph_q   <= '0;
        end else begin
            warm_q <= (warm_q == 3'd6) ? warm_q : warm_q + 3'd1;
            ph_q   <= ph_q + 2'd1;
        end
        armed_q <= !rst;
    end

    // R1: a reset edge leaves the output cleared.
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!out_valid && out_lanes == '0));

    // R2: strobes only on the expected cadence.
    p_first_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (warm_q == 3'd6 && ph_q == 2'd2));

    // R2: an unbroken stream yields a strobe every fourth cycle.
    p_cadence_r2: assert property (@(posedge clk) disable iff (rst)
        (warm_q == 3'd6 && ph_q == 2'd2) |-> out_valid);

    // R2: strobe lasts a single cycle.
    p_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R9: word holds between strobes.
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (armed_q && !out_valid) |-> $stable(out_lanes));

endmodule

bind ilv_deser ilv_deser_chk #(
    .OUT_W (ilv_pkg::SPLIT_N * ilv_pkg::CORE_N * ilv_pkg::SAMPLE_W)
) i_chk (
    .clk       (clk),
    .rst       (rst),
    .out_valid (out_valid),
    .out_lanes (out_lanes)
);

// File: tb/test_ilv_deser.sv
module test_ilv_deser;

    localparam int CLK_PERIOD = 10;
    localparam int SW = 12;
    localparam int NL = 16;
    localparam int OW = NL * SW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [47:0]   in_lanes = '0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_core = '0;
    logic          cfg_is_gain = 1'b0;
    logic [15:0]   cfg_wdata = '0;
    logic          out_valid;
    logic [OW-1:0] out_lanes;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    int gin [0:7][0:15];
    int off_c [0:3];
    int gain_c [0:3];
    int nw;
    int w_core [0:7];
    int w_isg [0:7];
    int w_val [0:7];

    ilv_deser i_ilv_deser (
        .clk         (clk),
        .rst         (rst),
        .in_lanes    (in_lanes),
        .cfg_we      (cfg_we),
        .cfg_core    (cfg_core),
        .cfg_is_gain (cfg_is_gain),
        .cfg_wdata   (cfg_wdata),
        .out_valid   (out_valid),
        .out_lanes   (out_lanes)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int trim_ref(int s, int o, int g);
        int p;
        int r;
        p = (s - o) * g;
        r = (p + 8192) >>> 14;
        if (r > 2047) r = 2047;
        if (r < -2048) r = -2048;
        return r;
    endfunction

    task automatic chk(string req, logic [OW-1:0] act, logic [OW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_unity();
        for (int c = 0; c < 4; c++) begin
            off_c[c]  = 0;
            gain_c[c] = 16384;
        end
        nw = 0;
    endtask

    task automatic add_write(int core, int isg, int val);
        w_core[nw] = core;
        w_isg[nw]  = isg;
        w_val[nw]  = val;
        if (isg != 0) gain_c[core] = val;
        else          off_c[core]  = val;
        nw++;
    endtask

    // R1, R8: reset, optionally attempting trim writes while it is held.
    task automatic do_reset(bit write_in_reset);
        @(negedge clk);
        rst = 1'b1;
        cfg_we = write_in_reset;
        cfg_core = 2'd0;
        cfg_is_gain = 1'b1;
        cfg_wdata = 16'h2000;
        repeat (3) @(negedge clk);
        chk("R1 valid", OW'(out_valid), OW'(1'b0));
        chk("R1 lanes", out_lanes, '0);
        cfg_we = 1'b0;
        rst = 1'b0;
    endtask

    // Drives ng groups on an unbroken stream and checks every cycle.
    task automatic stream(int ng, int skip, string tag);
        logic [OW-1:0] last_w;
        logic [OW-1:0] exp_w;
        last_w = '0;
        for (int j = 0; j <= 4*ng + 1; j++) begin
            int g;
            g = j / 4;
            for (int c = 0; c < 4; c++) begin
                if (g < ng) in_lanes[c*SW +: SW] = SW'(gin[g][4*(j%4) + c]);
                else        in_lanes[c*SW +: SW] = '0;
            end
            if (j < nw) begin
                cfg_we      = 1'b1;
                cfg_core    = 2'(w_core[j]);
                cfg_is_gain = (w_isg[j] != 0);
                cfg_wdata   = 16'(w_val[j]);
            end else begin
                cfg_we = 1'b0;
            end
            @(negedge clk);
            if (j >= 5 && ((j - 5) % 4) == 0) begin
                int go;
                go = (j - 5) / 4;
                chk("R2 strobe", OW'(out_valid), OW'(1'b1));
                if (go >= skip) begin
                    for (int k = 0; k < NL; k++)
                        exp_w[k*SW +: SW] = SW'(trim_ref(gin[go][k], off_c[k%4], gain_c[k%4]));
                    chk(tag, out_lanes, exp_w);
                    last_w = exp_w;
                end else begin
                    last_w = out_lanes;
                end
            end else begin
                chk("R2 idle", OW'(out_valid), OW'(1'b0));
                chk("R9 hold", out_lanes, last_w);
            end
        end
        cfg_we = 1'b0;
    endtask

    // R1 unity trims after reset, R3 time ordering.
    task automatic t_order();
        do_reset(1'b0);
        set_unity();
        for (int g = 0; g < 4; g++)
            for (int k = 0; k < NL; k++)
                gin[g][k] = k*111 - 900 + g*37;
        stream(4, 0, "R3 R1 order");
    endtask

    // R4, R7, R8: per-core offset and gain, shared by lanes k mod 4.
    task automatic t_trim();
        do_reset(1'b0);
        set_unity();
        add_write(0, 0, 0);
        add_write(1, 0, 5);
        add_write(2, 0, -3);
        add_write(3, 0, 12);
        add_write(0, 1, 16'h4000);
        add_write(1, 1, 16'h4200);
        add_write(2, 1, 16'h3E00);
        add_write(3, 1, 16'h4100);
        for (int g = 0; g < 5; g++)
            for (int k = 0; k < NL; k++)
                gin[g][k] = (k*257 + g*991) % 3000 - 1500;
        stream(5, 2, "R4 R7 R8 trim");
    endtask

    // R5: exact halves round toward positive infinity.
    task automatic t_round();
        do_reset(1'b0);
        set_unity();
        for (int c = 0; c < 4; c++) add_write(c, 1, 16'h6000);
        for (int g = 0; g < 3; g++)
            for (int k = 0; k < NL; k++)
                gin[g][k] = (k % 2 == 0) ? (k/2 + 1) : -(k/2 + 1);
        stream(3, 2, "R5 round");
    endtask

    // R6: clamp at both ends of the signed range.
    task automatic t_sat();
        do_reset(1'b0);
        set_unity();
        add_write(0, 1, 16'hFFFF);
        add_write(1, 1, 16'hFFFF);
        add_write(2, 0, -2048);
        add_write(3, 0, 2047);
        add_write(3, 1, 16'h8000);
        for (int g = 0; g < 3; g++)
            for (int k = 0; k < NL; k++)
                gin[g][k] = (k/4 % 2 == 0) ? 2047 : -2048;
        stream(3, 2, "R6 saturate");
    endtask

    // R8 writes during reset ignored; R10 mid-group reset realigns slot 0.
    task automatic t_reset_realign();
        @(negedge clk);
        in_lanes = 48'hABC_123_456_789;
        repeat (6) @(negedge clk);
        do_reset(1'b1);
        set_unity();
        for (int g = 0; g < 3; g++)
            for (int k = 0; k < NL; k++)
                gin[g][k] = 2000 - k*250 + g;
        stream(3, 0, "R8 R10 realign");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_order();
        t_trim();
        t_round();
        t_sat();
        t_reset_realign();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule